// File: doc/BRIEF.md
# Power-Fail and Pushbutton Reset Controller

This block drives an active-low, open-drain system reset line and a matching access-inhibit flag. A digital power-fail input from an external supply comparator holds the line low for as long as it is asserted. When power returns, the block keeps the line low for a further stretch of about 250 ms before it allows register access. If the oscillator was set to stop during backup, the block also waits until the oscillator reports that it is ready.

The block reads the same reset line that it pulls low, so a pushbutton wired to that line can start a reset. A press seen while idle starts a 250 ms stretch. If the button is still held when the stretch ends, the block lets go of the line and waits for the release. It then drives a second 250 ms stretch. A watchdog pulse request uses the same timer, but only while the block is idle.

The stretch is counted in ticks of a 4096 Hz strobe, so the default of 1024 ticks gives 250 ms. The output is an enable: when it is high the line is pulled low, and when it is low the line is left to its pull-up.

Top module: `rst_supervisor`

## Requirements
- R1: After `rst_n` is released, `rst_pull_o` is 1 and `access_ok_o` is 0 for HOLD_TICKS ticks. After that, `rst_pull_o` is 0 and `access_ok_o` is 1.
- R2: From any state, `pfail_i` at 1 makes `rst_pull_o` 1 and `access_ok_o` 0 from the next clock, and keeps them there while `pfail_i` stays 1.
- R3: When `pfail_i` returns to 0, `rst_pull_o` stays 1 for HOLD_TICKS more ticks before it is released.
- R4: If `osc_off_i` was 1 during power-fail, the block keeps driving `rst_pull_o` after the post-power-fail stretch until `osc_ready_i` is 1.
- R5: In idle, a falling edge on the synchronized `rst_line_i` (a 1 followed by a 0) drives `rst_pull_o` to 1 and `access_ok_o` to 0 for HOLD_TICKS ticks.
- R6: After the press stretch, the block releases the line for a settle window. If the line still reads 0 after that window, `rst_pull_o` stays 0 and `access_ok_o` stays 0 until the line rises.
- R7: A rising edge on the line while the block waits for the release drives `rst_pull_o` to 1 for another HOLD_TICKS ticks, after which the block returns to idle.
- R8: If the line reads 1 after the settle window, the block returns to idle with no second stretch.
- R9: The line going low because the block itself drives it never starts a new cycle. After any stretch ends, the block stays idle when no new stimulus arrives.
- R10: A one-cycle `wd_req_i` in idle drives a stretch of HOLD_TICKS ticks. A request in any other state is ignored and does not lengthen the current cycle.
- R11: `access_ok_o` is 1 only in idle. It is never 1 while `rst_pull_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfail_i | input | 1 | Power-fail from the supply comparator, active high |
| osc_off_i | input | 1 | Oscillator set to stop during backup |
| osc_ready_i | input | 1 | Oscillator running and stable |
| tick_i | input | 1 | One-cycle strobe at 4096 Hz |
| wd_req_i | input | 1 | Watchdog reset pulse request |
| rst_line_i | input | 1 | Sensed level of the reset line |
| rst_pull_o | output | 1 | 1 pulls the reset line low; 0 leaves it high impedance |
| access_ok_o | output | 1 | 1 when register access is allowed |

## Verification
The hardest situation to reach is a button still held when the first stretch ends. The block's own drive hides the button during the stretch, and the two-flop synchronizer delays what the block reads once it lets go. The bench models the line as a wired-AND of the block's enable and a button register. It holds the button through the whole first stretch and the settle window, then checks the waiting state: line released but access still blocked. It then releases the button and expects the second stretch. A short press, where the button is let go during the stretch, checks that the block does not run a second stretch and does not mistake the end of its own drive for a new press.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int HOLD_TICKS = 1024,
  parameter int SETTLE     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pfail_i,
  input  logic osc_off_i,
  input  logic osc_ready_i,
  input  logic tick_i,
  input  logic wd_req_i,
  input  logic rst_line_i,
  output logic rst_pull_o,
  output logic access_ok_o
);
  localparam int CW = $clog2(HOLD_TICKS + SETTLE) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PFAIL, ST_PUP, ST_OSC, ST_PRESS, ST_CHECK, ST_RELWAIT, ST_HOLD2
  } state_t;

  state_t        state, nxt;
  logic [CW-1:0] cnt;
  logic          sync1, line_s, line_q, osc_slow;
  logic          hold_done, settle_done, fall, rise;

  assign hold_done   = tick_i && (cnt == CW'(HOLD_TICKS - 1));
  assign settle_done = (cnt == CW'(SETTLE - 1));
  assign fall        = line_q && !line_s;
  assign rise        = !line_q && line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b1;
      line_s <= 1'b1;
      line_q <= 1'b1;
    end else begin
      sync1  <= rst_line_i;
      line_s <= sync1;
      line_q <= line_s;
    end
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (fall) nxt = ST_PRESS;
                  else if (wd_req_i) nxt = ST_HOLD2;
      ST_PFAIL:   if (!pfail_i) nxt = ST_PUP;
      ST_PUP:     if (hold_done) nxt = (osc_slow && !osc_ready_i) ? ST_OSC : ST_IDLE;
      ST_OSC:     if (osc_ready_i) nxt = ST_IDLE;
      ST_PRESS:   if (hold_done) nxt = ST_CHECK;
      ST_CHECK:   if (settle_done) nxt = line_s ? ST_IDLE : ST_RELWAIT;
      ST_RELWAIT: if (rise) nxt = ST_HOLD2;
      ST_HOLD2:   if (hold_done) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
    if (pfail_i) nxt = ST_PFAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PUP;
      cnt      <= '0;
      osc_slow <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else if (tick_i || state == ST_CHECK) cnt <= cnt + 1'b1;
      if (state == ST_PFAIL) osc_slow <= osc_off_i;
    end
  end

  assign rst_pull_o  = (state == ST_PFAIL) || (state == ST_PUP) || (state == ST_OSC) ||
                       (state == ST_PRESS) || (state == ST_HOLD2);
  assign access_ok_o = (state == ST_IDLE);

  AST_PFAIL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_i |=> rst_pull_o); // R2
  AST_PFAIL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_i |=> !access_ok_o); // R2
  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pull_o |-> !access_ok_o); // R11
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pull_o && !tick_i && !osc_ready_i && !pfail_i) |=> rst_pull_o); // R3
  AST_OSC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OSC && !osc_ready_i && !pfail_i) |=> rst_pull_o); // R4
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfail = 1'b0, osc_off = 1'b0, osc_ready = 1'b0, tick = 1'b0, wd_req = 1'b0;
  logic button = 1'b0;
  logic pull, acc, line;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) tick <= ~tick;

  assign line = (pull || button) ? 1'b0 : 1'b1;

  rst_supervisor #(.HOLD_TICKS(8), .SETTLE(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .pfail_i(pfail), .osc_off_i(osc_off),
    .osc_ready_i(osc_ready), .tick_i(tick), .wd_req_i(wd_req),
    .rst_line_i(line), .rst_pull_o(pull), .access_ok_o(acc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_st(input string req, input bit p, input bit a);
    chk(pull == p, req, pull, p);
    chk(acc == a, req, acc, a);
  endtask

  task automatic t_reset();
    cyc(3); rst_n = 1'b1; cyc(1);
    expect_st("R1 reset drive", 1, 0);
    cyc(10); expect_st("R1 hold", 1, 0);
    cyc(12); expect_st("R1 released R11", 0, 1);
  endtask

  task automatic t_pfail();
    pfail = 1'b1; cyc(1);
    expect_st("R2 assert", 1, 0);
    cyc(20); expect_st("R2 held", 1, 0);
    pfail = 1'b0; cyc(10);
    expect_st("R3 post hold", 1, 0);
    cyc(12); expect_st("R3 released", 0, 1);
  endtask

  task automatic t_osc();
    osc_off = 1'b1; osc_ready = 1'b0;
    pfail = 1'b1; cyc(5); pfail = 1'b0;
    cyc(30); expect_st("R4 osc wait", 1, 0);
    osc_ready = 1'b1; cyc(2);
    expect_st("R4 osc ready", 0, 1);
    osc_off = 1'b0;
  endtask

  task automatic t_press_short();
    button = 1'b1; cyc(3); button = 1'b0;
    cyc(1); expect_st("R5 press", 1, 0);
    cyc(30); expect_st("R8 no second", 0, 1);
    cyc(20); expect_st("R9 stays idle", 0, 1);
  endtask

  task automatic t_press_long();
    button = 1'b1; cyc(4);
    expect_st("R5 long press", 1, 0);
    cyc(36); expect_st("R6 wait release", 0, 0);
    cyc(20); expect_st("R6 still waiting", 0, 0);
    button = 1'b0; cyc(5);
    expect_st("R7 second hold", 1, 0);
    cyc(10); expect_st("R7 still held", 1, 0);
    cyc(14); expect_st("R7 idle", 0, 1);
    cyc(20); expect_st("R9 no self edge", 0, 1);
  endtask

  task automatic t_wdog();
    wd_req = 1'b1; cyc(1); wd_req = 1'b0;
    expect_st("R10 wd start", 1, 0);
    cyc(10); expect_st("R10 wd hold", 1, 0);
    cyc(14); expect_st("R10 wd done", 0, 1);
  endtask

  task automatic t_wdog_ignored();
    button = 1'b1; cyc(3); button = 1'b0;
    cyc(6); wd_req = 1'b1; cyc(1); wd_req = 1'b0;
    cyc(24); expect_st("R10 wd ignored", 0, 1);
    cyc(20); expect_st("R10 no late wd", 0, 1);
  endtask

  task automatic t_pfail_mid();
    button = 1'b1; cyc(3); button = 1'b0;
    cyc(3); pfail = 1'b1; cyc(30);
    expect_st("R2 pfail mid press", 1, 0);
    pfail = 1'b0; cyc(10);
    expect_st("R3 hold after mid", 1, 0);
    cyc(12); expect_st("R3 idle after mid", 0, 1);
  endtask

  initial begin
    t_reset();
    t_pfail();
    t_osc();
    t_press_short();
    t_press_long();
    t_wdog();
    t_wdog_ignored();
    t_pfail_mid();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule